// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Controller

This block decides, every cycle, whether the instruction sitting in decode of a five-stage in-order pipeline may move on. The pipeline has no forwarding, resolves branches in decode, and lets the register file write in the first half of a cycle and read in the second. The block compares the decode instruction's source registers against the destinations of the instructions now in execute and in memory. Any live match holds the front of the pipeline and sends an empty slot into execute. A producer that has reached write-back is never compared, because its value is read through the register file in the same cycle.

The controller keeps no state. Each cycle its decision comes from whatever the EX and MEM pipeline registers hold. A producer one instruction ahead therefore holds decode for two cycles: it is first seen in execute and then in memory. A producer two instructions ahead holds decode for one cycle. When several producers conflict, the nearest one sets how long decode waits. When a branch in decode is taken, the controller also discards the instruction fetched behind it. It does this only in a cycle when decode is not held.

Every pin is a plain level-sensitive control signal. There is no data stream crossing this block, so there is no valid/ready handshake and no back-pressure rule.

Top module: `hz_stall_ctrl`

## Requirements
- R1: When a used decode source equals the execute-stage destination, that destination is nonzero and the execute write enable is 1, `hold_front` is 1 in the same cycle.
- R2: When a used decode source equals the memory-stage destination, that destination is nonzero and the memory write enable is 1, `hold_front` is 1 in the same cycle.
- R3: When neither rule R1 nor rule R2 applies, `hold_front` is 0. This includes a producer three or more instructions ahead, which has already left the memory stage.
- R4: A destination or source equal to register 0 never raises `hold_front`.
- R5: A source whose use flag is 0 never raises `hold_front`, whatever its register number.
- R6: A destination whose write enable is 0 never raises `hold_front`.
- R7: `bubble_ex` equals `hold_front` in every cycle.
- R8: `flush_fetch` is 1 exactly when `id_is_branch` is 1, `id_br_taken` is 1 and `hold_front` is 0. A taken flag without a branch has no effect.
- R9: Assume a pipeline that freezes decode and inserts an empty slot into execute while `hold_front` is 1. A consumer directly behind its producer is held for exactly 2 cycles. One with one instruction between them is held for exactly 1 cycle. One with two instructions between them is not held.
- R10: When a consumer depends on two producers at different distances, it is held for the larger of the two individual stall counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register of the decode instruction |
| id_use_a | input | 1 | First source is actually read |
| id_src_b | input | REG_W | Second source register of the decode instruction |
| id_use_b | input | 1 | Second source is actually read |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Decode-stage comparison says the branch is taken |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes its destination |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes its destination |
| hold_front | output | 1 | Freeze the PC and the fetch/decode register |
| bubble_ex | output | 1 | Load an empty slot, all write enables cleared, into execute |
| flush_fetch | output | 1 | Discard the instruction fetched behind a taken branch |

## Verification
The bench sweeps every combination of source numbers, use flags, destinations, write enables and branch flags over a four-register configuration. This exposes a design that lets register 0 match, ignores a use flag or write enable, or compares against the wrong stage. A flush that is not gated by the hold would discard the fetched instruction while a stalled branch still has stale operands. A design that counted stall cycles on its own, instead of re-reading the stages, would go wrong on the timed runs. There, a small pipeline model advances producers and consumers at distances one, two and three, and also runs mixed two-producer cases. An over-counting design would hold a distance-two consumer twice. A design that let the farther producer win would release early.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Remaining cycles a decode instruction must wait for a single producer.
  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_ONE  = 2'd1,
    HZ_TWO  = 2'd2
  } hz_need_e;

  localparam int unsigned HZ_NEED_W = 2;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0]          src,
  input  logic [NUM_SRC-1:0]                     use_src,
  input  logic [REG_W-1:0]                       ex_dst,
  input  logic                                   ex_we,
  input  logic [REG_W-1:0]                       mem_dst,
  input  logic                                   mem_we,
  output logic [NUM_SRC-1:0][hz_pkg::HZ_NEED_W-1:0] need
);
  import hz_pkg::*;

  logic ex_live;
  logic mem_live;

  // A stage only produces a hazard if it writes a real (nonzero) register.
  assign ex_live  = ex_we  && (ex_dst  != '0);
  assign mem_live = mem_we && (mem_dst != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit_ex;
    logic hit_mem;
    assign hit_ex  = use_src[i] && ex_live  && (src[i] == ex_dst);
    assign hit_mem = use_src[i] && mem_live && (src[i] == mem_dst);
    // Execute is the nearer producer, so it needs the longer wait.
    always_comb begin
      if (hit_ex)       need[i] = HZ_TWO;
      else if (hit_mem) need[i] = HZ_ONE;
      else              need[i] = HZ_NONE;
    end
  end
endmodule

// File: rtl/hz_demand_merge.sv
module hz_demand_merge #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][hz_pkg::HZ_NEED_W-1:0] need,
  output logic [hz_pkg::HZ_NEED_W-1:0]              need_max,
  output logic                                      stall
);
  import hz_pkg::*;

  // Largest outstanding wait across all sources.
  always_comb begin
    need_max = HZ_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (need[i] > need_max) need_max = need[i];
    end
  end

  assign stall = (need_max != HZ_NONE);
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic is_branch,
  input  logic taken,
  input  logic stall,
  output logic flush
);
  // A branch held by a data hazard has stale operands; its outcome waits.
  assign flush = is_branch && taken && !stall;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_src_a,
  input  logic             id_use_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_use_b,
  input  logic             id_is_branch,
  input  logic             id_br_taken,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_we,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_we,
  output logic             hold_front,
  output logic             bubble_ex,
  output logic             flush_fetch
);
  import hz_pkg::*;

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0]     src_vec;
  logic [NUM_SRC-1:0]                use_vec;
  logic [NUM_SRC-1:0][HZ_NEED_W-1:0] need_vec;
  logic [HZ_NEED_W-1:0]              need_max;
  logic                              stall_w;

  assign src_vec = {id_src_b, id_src_a};
  assign use_vec = {id_use_b, id_use_a};

  hz_src_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_match (
    .src     (src_vec),
    .use_src (use_vec),
    .ex_dst  (ex_dst),
    .ex_we   (ex_we),
    .mem_dst (mem_dst),
    .mem_we  (mem_we),
    .need    (need_vec)
  );

  hz_demand_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .need     (need_vec),
    .need_max (need_max),
    .stall    (stall_w)
  );

  hz_redirect u_redir (
    .is_branch (id_is_branch),
    .taken     (id_br_taken),
    .stall     (stall_w),
    .flush     (flush_fetch)
  );

  // The wait depth is re-derived each cycle as producers advance.
  logic unused_depth;
  assign unused_depth = ^need_max;

  assign hold_front = stall_w;
  assign bubble_ex  = stall_w;
endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] id_src_a,
  input logic             id_use_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             id_use_b,
  input logic             id_is_branch,
  input logic             id_br_taken,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_we,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_we,
  input logic             hold_front,
  input logic             bubble_ex,
  input logic             flush_fetch
);
  always_comb begin
    p_ex_hit_r1: assert (!(id_use_a && ex_we && ex_dst != '0 && id_src_a == ex_dst) || hold_front)
      else $error("execute-stage match did not hold decode");
    p_mem_hit_r2: assert (!(id_use_b && mem_we && mem_dst != '0 && id_src_b == mem_dst) || hold_front)
      else $error("memory-stage match did not hold decode");
    p_zero_reg_r4: assert (!(ex_dst == '0 && mem_dst == '0) || !hold_front)
      else $error("register 0 created a hazard");
    p_unused_r5: assert (!(!id_use_a && !id_use_b) || !hold_front)
      else $error("unused sources created a hazard");
    p_no_writer_r6: assert (!(!ex_we && !mem_we) || !bubble_ex)
      else $error("no writer in flight but bubble inserted");
    p_flush_excl_r8: assert (!(flush_fetch && hold_front))
      else $error("flush while decode held");
    p_flush_cause_r8: assert (!flush_fetch || (id_is_branch && id_br_taken))
      else $error("flush without taken branch");
  end
endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hz_stall_ctrl_test.sv
module hz_stall_ctrl_test;
  localparam int unsigned RW = 2;
  localparam int unsigned NR = 1 << RW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0;
  logic id_use_a = 0, id_use_b = 0, id_is_branch = 0, id_br_taken = 0, ex_we = 0, mem_we = 0;
  logic hold_front, bubble_ex, flush_fetch;

  int checks = 0;
  int bad = 0;

  hz_stall_ctrl #(.REG_W(RW)) uut (
    .id_src_a(id_src_a), .id_use_a(id_use_a), .id_src_b(id_src_b), .id_use_b(id_use_b),
    .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_dst(ex_dst), .ex_we(ex_we), .mem_dst(mem_dst), .mem_we(mem_we),
    .hold_front(hold_front), .bubble_ex(bubble_ex), .flush_fetch(flush_fetch)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Small program for the timed pipeline model.
  logic [RW-1:0] p_dst [8];
  logic [RW-1:0] p_sa  [8];
  logic [RW-1:0] p_sb  [8];
  logic          p_we  [8];
  logic          p_ua  [8];
  logic          p_ub  [8];

  task automatic set_ins(input int i, input logic we, input int d,
                         input logic ua, input int sa, input logic ub, input int sb);
    p_we[i] = we; p_dst[i] = RW'(d);
    p_ua[i] = ua; p_sa[i] = RW'(sa);
    p_ub[i] = ub; p_sb[i] = RW'(sb);
  endtask

  task automatic set_nop(input int i);
    set_ins(i, 1'b0, 0, 1'b0, 0, 1'b0, 0);
  endtask

  // Runs n instructions; counts cycles the last one spends held in decode.
  task automatic run_prog(input int n, output int held);
    int pc = 0;
    logic [RW-1:0] exd = '0, memd = '0;
    logic exw = 1'b0, memw = 1'b0;
    logic s;
    held = 0;
    for (int cyc = 0; cyc < n + 6; cyc++) begin
      if (pc < n) begin
        id_src_a = p_sa[pc]; id_use_a = p_ua[pc];
        id_src_b = p_sb[pc]; id_use_b = p_ub[pc];
      end else begin
        id_src_a = '0; id_use_a = 1'b0; id_src_b = '0; id_use_b = 1'b0;
      end
      ex_dst = exd; ex_we = exw; mem_dst = memd; mem_we = memw;
      #2;
      s = hold_front;
      if (pc == n - 1 && s) held++;
      @(posedge clk);
      #1;
      memd = exd; memw = exw;
      if (s) begin
        exd = '0; exw = 1'b0;
      end else begin
        if (pc < n) begin exd = p_dst[pc]; exw = p_we[pc]; end
        else begin exd = '0; exw = 1'b0; end
        pc++;
      end
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int held;
    @(posedge clk); #3;
    // Idle pipeline: nothing in flight, nothing asserted (R3, R7, R8).
    chk("R3 idle hold", hold_front, 0);
    chk("R7 idle bubble", bubble_ex, 0);
    chk("R8 idle flush", flush_fetch, 0);

    // Exhaustive sweep over a four-register configuration.
    for (int a = 0; a < NR; a++)
    for (int b = 0; b < NR; b++)
    for (int u = 0; u < 4; u++)
    for (int ed = 0; ed < NR; ed++)
    for (int ew = 0; ew < 2; ew++)
    for (int md = 0; md < NR; md++)
    for (int mw = 0; mw < 2; mw++)
    for (int br = 0; br < 4; br++) begin
      bit ua, ub, exh, memh, zero_m, unused_m, we_m, es, ef;
      string tag;
      ua = u[0]; ub = u[1];
      id_src_a = RW'(a); id_src_b = RW'(b); id_use_a = ua; id_use_b = ub;
      ex_dst = RW'(ed); ex_we = ew[0]; mem_dst = RW'(md); mem_we = mw[0];
      id_is_branch = br[0]; id_br_taken = br[1];
      #1;
      exh  = ew[0] && ed != 0 && ((ua && a == ed) || (ub && b == ed));
      memh = mw[0] && md != 0 && ((ua && a == md) || (ub && b == md));
      zero_m   = (ed == 0 && ((ua && a == 0) || (ub && b == 0))) ||
                 (md == 0 && ((ua && a == 0) || (ub && b == 0)));
      unused_m = (!ua && (a == ed || a == md)) || (!ub && (b == ed || b == md));
      we_m     = (!ew[0] && (a == ed || b == ed)) || (!mw[0] && (a == md || b == md));
      es = exh || memh;
      ef = br[0] && br[1] && !es;
      if (exh)           tag = "R1 ex match";
      else if (memh)     tag = "R2 mem match";
      else if (zero_m)   tag = "R4 reg zero";
      else if (unused_m) tag = "R5 unused src";
      else if (we_m)     tag = "R6 no write";
      else               tag = "R3 clear";
      chk(tag, hold_front, es);
      chk("R7 bubble", bubble_ex, es);
      chk("R8 flush", flush_fetch, ef);
    end
    id_is_branch = 0; id_br_taken = 0;
    @(posedge clk); #1;

    // R9: distance 1 -> 2 cycles.
    set_ins(0, 1, 1, 0, 0, 0, 0);
    set_ins(1, 1, 2, 1, 1, 0, 0);
    run_prog(2, held);
    chk("R9 distance one", held, 2);

    // R9: distance 1 on second source.
    set_ins(0, 1, 3, 0, 0, 0, 0);
    set_ins(1, 1, 2, 0, 0, 1, 3);
    run_prog(2, held);
    chk("R9 distance one src b", held, 2);

    // R9: distance 2 -> 1 cycle.
    set_ins(0, 1, 1, 0, 0, 0, 0);
    set_nop(1);
    set_ins(2, 1, 2, 1, 1, 0, 0);
    run_prog(3, held);
    chk("R9 distance two", held, 1);

    // R3 / R9: distance 3 -> no stall (producer in write-back).
    set_ins(0, 1, 1, 0, 0, 0, 0);
    set_nop(1);
    set_nop(2);
    set_ins(3, 1, 2, 1, 1, 1, 1);
    run_prog(4, held);
    chk("R3 distance three", held, 0);

    // R4: producer writes register 0, consumer reads it.
    set_ins(0, 1, 0, 0, 0, 0, 0);
    set_ins(1, 1, 2, 1, 0, 1, 0);
    run_prog(2, held);
    chk("R4 zero producer", held, 0);

    // R10: sources at distance 2 and 1 -> 2 cycles.
    set_ins(0, 1, 1, 0, 0, 0, 0);
    set_ins(1, 1, 2, 0, 0, 0, 0);
    set_ins(2, 1, 3, 1, 1, 1, 2);
    run_prog(3, held);
    chk("R10 mixed a far b near", held, 2);

    set_ins(2, 1, 3, 1, 2, 1, 1);
    run_prog(3, held);
    chk("R10 mixed a near b far", held, 2);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule